// File: doc/BRIEF.md
# Six-Channel I/Q Output Port Formatter

This block collects baseband I/Q samples from six receive channels and sends them out as a single stream of 16-bit words on one parallel output port. Each channel has a one-entry holding register. On every port-clock cycle the block picks the lowest-numbered enabled channel that has a sample waiting and emits that sample's words. A format input selects one of two layouts. In the first, I and Q go out as two consecutive full-width words. In the second, both are packed into one word, eight bits each. An RSSI word can follow a sample. This happens either after every sample or only after the first sample that follows an RSSI update on that channel.

The port cadence comes from one of two sources. In master mode the block divides its fast clock by 1, 2, 4 or 8, produces the port clock itself and drives it out. In slave mode it follows the rising edges of an external port clock. All logic runs on the fast clock. The port clock only sets the pace at which words are released, so each word appears as a one-fast-cycle `out_valid` pulse and its data is held until the next word.

Top module: `iq_port_fmt`

## Requirements
- R1: A channel's samples are accepted and sent only while its bit in `ch_en` is 1. A sample that arrives on a disabled channel is dropped: it produces no output word and does not set `overflow`.
- R2: When several channels have a sample waiting, they are served in ascending channel number. One sample is started per port cycle, and all words of that sample go out before the next sample starts.
- R3: With `fmt_par` = 0, a sample produces an I word (tag 2'b00, `out_data` = full 16-bit I) followed on the next port cycle by a Q word (tag 2'b01, `out_data` = full 16-bit Q). Both words carry the channel number on `out_ch`.
- R4: With `fmt_par` = 1, a sample produces a single word with tag 2'b11. Bits [15:8] of that word hold I[15:8] and bits [7:0] hold Q[15:8].
- R5: With `rssi_every` = 1, each sample is followed on the next port cycle by an RSSI word (tag 2'b10) that carries the channel's most recently written RSSI value. This holds whether or not the RSSI was updated since the last sample.
- R6: With `rssi_every` = 0, an RSSI word follows a sample only if the channel's RSSI was written since that channel's last RSSI word was sent. Later samples carry no RSSI word until the next write.
- R7: Output words appear only on port cycles. `out_valid` is a single fast-clock pulse per word, and `out_tag`, `out_ch` and `out_data` hold their values until the next word.
- R8: In master mode (`pclk_master` = 1), port cycles occur every 1, 2, 4 or 8 fast-clock cycles for `pclk_div` codes 00, 01, 10 and 11. `pclk_oe` is 1. For divisors of 2 and above, `pclk_out` is high for half of each port period.
- R9: In slave mode (`pclk_master` = 0), port cycles follow the rising edges of `pclk_in` and `pclk_div` has no effect. `pclk_oe` and `pclk_out` are both 0.
- R10: While reset is asserted, `pclk_oe`, `out_valid` and `overflow` are 0 whatever the value of `pclk_master`. The port clock pin is therefore an input coming out of reset.
- R11: If a new sample arrives on an enabled channel while the previous one is still waiting, the newer sample replaces it and that channel's `overflow` bit is set. The bit stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast clock; all logic runs on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_en | input | 6 | Per-channel output enable mask |
| fmt_par | input | 1 | 1: packed 8+8 word; 0: I and Q as separate 16-bit words |
| rssi_every | input | 1 | 1: RSSI after every sample; 0: only after an RSSI update |
| pclk_master | input | 1 | 1: port clock generated internally; 0: taken from pclk_in |
| pclk_div | input | 2 | Master divisor code (00:1, 01:2, 10:4, 11:8) |
| pclk_in | input | 1 | External port clock used in slave mode |
| pclk_out | output | 1 | Generated port clock in master mode |
| pclk_oe | output | 1 | Output enable for the port clock pin |
| smp_vld | input | 6 | Per-channel new-sample strobe |
| smp_i | input | 96 | I samples, 16 bits per channel, channel 0 in the low bits |
| smp_q | input | 96 | Q samples, same packing as smp_i |
| rssi_upd | input | 6 | Per-channel RSSI write strobe |
| rssi_val | input | 96 | RSSI values, same packing as smp_i |
| out_valid | output | 1 | One-cycle pulse marking a new output word |
| out_tag | output | 2 | Word kind: 00 I, 01 Q, 10 RSSI, 11 packed I/Q |
| out_ch | output | 3 | Channel the word belongs to |
| out_data | output | 16 | Output word |
| overflow | output | 6 | Sticky per-channel overwrite flags |

## Verification
A fault in the serving order or the enable gating shows at the ports within a few port cycles: words carry the wrong `out_ch` or come from a disabled channel. A corrupted sequencer state shows up as a Q or RSSI word that does not directly follow the matching I or sample word. A freshness flag that is wrong in either direction adds or drops an RSSI word on the very next sample of that channel. A wrong divisor or a wrong slave edge detector changes the spacing between consecutive `out_valid` pulses. A fault in the holding register either loses the newer sample, which shows in the next word's data, or leaves `overflow` unset right after the second write.

// File: rtl/iq_fmt_pkg.sv
package iq_fmt_pkg;

  typedef enum logic [1:0] {
    TAG_I    = 2'b00,
    TAG_Q    = 2'b01,
    TAG_RSSI = 2'b10,
    TAG_IQ8  = 2'b11
  } word_tag_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_Q    = 2'b01,
    ST_RSSI = 2'b10
  } seq_st_e;

  // Port divisor for a 2-bit code: 1, 2, 4 or 8.
  function automatic logic [3:0] div_of(input logic [1:0] code);
    return 4'd1 << code;
  endfunction

  // Index of the lowest set bit, or -1 when none is set.
  function automatic int lowest_set(input logic [31:0] v);
    int r;
    r = -1;
    for (int k = 31; k >= 0; k--) begin
      if (v[k]) r = k;
    end
    return r;
  endfunction

endpackage

// File: rtl/iq_pclk_gen.sv
module iq_pclk_gen (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       master_cfg,
  input  logic [1:0] div_code,
  input  logic       pclk_in,
  output logic       tick,
  output logic       pclk_out,
  output logic       pclk_oe
);
  import iq_fmt_pkg::*;

  logic       master_q;
  logic [2:0] cnt;
  logic [2:0] cnt_n;
  logic [2:0] sync_q;
  logic [3:0] div;
  logic       m_tick;
  logic       s_tick;

  assign div    = div_of(div_code);
  assign m_tick = master_q && ({1'b0, cnt} >= (div - 4'd1));
  assign s_tick = !master_q && sync_q[1] && !sync_q[2];
  assign tick   = m_tick || s_tick;
  assign cnt_n  = (!master_q || m_tick) ? 3'd0 : cnt + 3'd1;
  assign pclk_oe = master_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      master_q <= 1'b0;
      cnt      <= '0;
      sync_q   <= '0;
      pclk_out <= 1'b0;
    end else begin
      master_q <= master_cfg;
      cnt      <= cnt_n;
      sync_q   <= {sync_q[1:0], pclk_in};
      pclk_out <= master_cfg && ((div == 4'd1) || ({1'b0, cnt_n} < (div >> 1)));
    end
  end

endmodule

// File: rtl/iq_chan_hold.sv
module iq_chan_hold #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          smp_vld,
  input  logic [DW-1:0] smp_i,
  input  logic [DW-1:0] smp_q,
  input  logic          rssi_upd,
  input  logic [DW-1:0] rssi_val,
  input  logic          take,
  input  logic          rssi_clr,
  output logic          pend,
  output logic [DW-1:0] hold_i,
  output logic [DW-1:0] hold_q,
  output logic [DW-1:0] rssi_q,
  output logic          fresh,
  output logic          ovf,
  output logic          ovf_evt
);

  logic accept;

  assign accept  = smp_vld && en;
  assign ovf_evt = accept && pend && !take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend   <= 1'b0;
      hold_i <= '0;
      hold_q <= '0;
      rssi_q <= '0;
      fresh  <= 1'b0;
      ovf    <= 1'b0;
    end else begin
      if (accept) begin
        hold_i <= smp_i;
        hold_q <= smp_q;
      end
      if (ovf_evt) ovf <= 1'b1;
      pend <= accept ? 1'b1 : (take ? 1'b0 : pend);
      if (rssi_upd) rssi_q <= rssi_val;
      fresh <= rssi_upd ? 1'b1 : (rssi_clr ? 1'b0 : fresh);
    end
  end

endmodule

// File: rtl/iq_port_seq.sv
module iq_port_seq #(
  parameter int NCH = 6,
  parameter int DW  = 16,
  parameter int CHW = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick,
  input  logic [NCH-1:0]          eligible,
  input  logic [NCH-1:0]          fresh,
  input  logic [NCH-1:0][DW-1:0]  hold_i,
  input  logic [NCH-1:0][DW-1:0]  hold_q,
  input  logic [NCH-1:0][DW-1:0]  rssi,
  input  logic                    fmt_par,
  input  logic                    rssi_every,
  output logic [NCH-1:0]          take,
  output logic [NCH-1:0]          rssi_clr,
  output logic                    out_valid,
  output logic [1:0]              out_tag,
  output logic [CHW-1:0]          out_ch,
  output logic [DW-1:0]           out_data
);
  import iq_fmt_pkg::*;

  localparam int HW = DW / 2;

  function automatic logic [DW-1:0] pack_halves(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return {a[DW-1 -: HW], b[DW-1 -: HW]};
  endfunction

  seq_st_e        st;
  logic [DW-1:0]  q_lat;
  logic [DW-1:0]  r_lat;
  logic           need_r;
  int             sel;
  logic           found;
  logic [CHW-1:0] sel_ch;
  logic           grant;
  logic           need_now;

  always_comb begin
    sel      = lowest_set(32'(eligible));
    found    = (sel >= 0);
    sel_ch   = sel[CHW-1:0];
    grant    = tick && (st == ST_IDLE) && found;
    need_now = rssi_every || fresh[sel_ch];
    take     = '0;
    rssi_clr = '0;
    if (grant) begin
      take[sel_ch]     = 1'b1;
      rssi_clr[sel_ch] = need_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      q_lat     <= '0;
      r_lat     <= '0;
      need_r    <= 1'b0;
      out_valid <= 1'b0;
      out_tag   <= TAG_I;
      out_ch    <= '0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      if (tick) begin
        unique case (st)
          ST_IDLE: begin
            if (found) begin
              q_lat     <= hold_q[sel_ch];
              r_lat     <= rssi[sel_ch];
              need_r    <= need_now;
              out_valid <= 1'b1;
              out_ch    <= sel_ch;
              if (fmt_par) begin
                out_tag  <= TAG_IQ8;
                out_data <= pack_halves(hold_i[sel_ch], hold_q[sel_ch]);
                st       <= need_now ? ST_RSSI : ST_IDLE;
              end else begin
                out_tag  <= TAG_I;
                out_data <= hold_i[sel_ch];
                st       <= ST_Q;
              end
            end
          end
          ST_Q: begin
            out_valid <= 1'b1;
            out_tag   <= TAG_Q;
            out_data  <= q_lat;
            st        <= need_r ? ST_RSSI : ST_IDLE;
          end
          default: begin
            out_valid <= 1'b1;
            out_tag   <= TAG_RSSI;
            out_data  <= r_lat;
            st        <= ST_IDLE;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/iq_port_fmt.sv
module iq_port_fmt #(
  parameter int NCH = 6,
  parameter int DW  = 16
) (
  input  logic                     clk_fast,
  input  logic                     rst_n,
  input  logic [NCH-1:0]           ch_en,
  input  logic                     fmt_par,
  input  logic                     rssi_every,
  input  logic                     pclk_master,
  input  logic [1:0]               pclk_div,
  input  logic                     pclk_in,
  output logic                     pclk_out,
  output logic                     pclk_oe,
  input  logic [NCH-1:0]           smp_vld,
  input  logic [NCH*DW-1:0]        smp_i,
  input  logic [NCH*DW-1:0]        smp_q,
  input  logic [NCH-1:0]           rssi_upd,
  input  logic [NCH*DW-1:0]        rssi_val,
  output logic                     out_valid,
  output logic [1:0]               out_tag,
  output logic [$clog2(NCH)-1:0]   out_ch,
  output logic [DW-1:0]            out_data,
  output logic [NCH-1:0]           overflow
);
  localparam int CHW = $clog2(NCH);

  logic                   port_tick;
  logic [NCH-1:0]         pend_v;
  logic [NCH-1:0]         fresh_v;
  logic [NCH-1:0]         take_v;
  logic [NCH-1:0]         rclr_v;
  logic [NCH-1:0]         ovf_evt_v;
  logic [NCH-1:0][DW-1:0] hold_i_v;
  logic [NCH-1:0][DW-1:0] hold_q_v;
  logic [NCH-1:0][DW-1:0] rssi_v;

  iq_pclk_gen u_pclk (
    .clk        (clk_fast),
    .rst_n      (rst_n),
    .master_cfg (pclk_master),
    .div_code   (pclk_div),
    .pclk_in    (pclk_in),
    .tick       (port_tick),
    .pclk_out   (pclk_out),
    .pclk_oe    (pclk_oe)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    iq_chan_hold #(.DW(DW)) u_hold (
      .clk      (clk_fast),
      .rst_n    (rst_n),
      .en       (ch_en[c]),
      .smp_vld  (smp_vld[c]),
      .smp_i    (smp_i[c*DW +: DW]),
      .smp_q    (smp_q[c*DW +: DW]),
      .rssi_upd (rssi_upd[c]),
      .rssi_val (rssi_val[c*DW +: DW]),
      .take     (take_v[c]),
      .rssi_clr (rclr_v[c]),
      .pend     (pend_v[c]),
      .hold_i   (hold_i_v[c]),
      .hold_q   (hold_q_v[c]),
      .rssi_q   (rssi_v[c]),
      .fresh    (fresh_v[c]),
      .ovf      (overflow[c]),
      .ovf_evt  (ovf_evt_v[c])
    );
  end

  iq_port_seq #(.NCH(NCH), .DW(DW), .CHW(CHW)) u_seq (
    .clk        (clk_fast),
    .rst_n      (rst_n),
    .tick       (port_tick),
    .eligible   (pend_v & ch_en),
    .fresh      (fresh_v),
    .hold_i     (hold_i_v),
    .hold_q     (hold_q_v),
    .rssi       (rssi_v),
    .fmt_par    (fmt_par),
    .rssi_every (rssi_every),
    .take       (take_v),
    .rssi_clr   (rclr_v),
    .out_valid  (out_valid),
    .out_tag    (out_tag),
    .out_ch     (out_ch),
    .out_data   (out_data)
  );

endmodule

// File: rtl/iq_port_fmt_chk.sv
module iq_port_fmt_chk #(
  parameter int NCH = 6
) (
  input logic                   clk_fast,
  input logic                   rst_n,
  input logic [NCH-1:0]         ch_en,
  input logic                   pclk_out,
  input logic                   pclk_oe,
  input logic                   out_valid,
  input logic [1:0]             out_tag,
  input logic [$clog2(NCH)-1:0] out_ch,
  input logic [NCH-1:0]         overflow,
  input logic                   port_tick,
  input logic [NCH-1:0]         take_v,
  input logic [NCH-1:0]         ovf_evt_v
);
  import iq_fmt_pkg::*;

  logic [NCH-1:0]         en_d;
  logic                   exp_q;
  logic [$clog2(NCH)-1:0] last_ch;
  logic [1:0]             last_tag;

  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n) begin
      en_d     <= '0;
      exp_q    <= 1'b0;
      last_ch  <= '0;
      last_tag <= TAG_RSSI;
    end else begin
      en_d <= ch_en;
      if (out_valid) begin
        exp_q    <= (out_tag == TAG_I);
        last_ch  <= out_ch;
        last_tag <= out_tag;
      end
    end
  end

  AST_ENABLED_ONLY: assert property (@(posedge clk_fast) disable iff (!rst_n)
    out_valid && (out_tag == TAG_I || out_tag == TAG_IQ8) |-> en_d[out_ch]); // R1

  AST_ONE_GRANT: assert property (@(posedge clk_fast) disable iff (!rst_n)
    $onehot0(take_v)); // R2

  AST_Q_AFTER_I: assert property (@(posedge clk_fast) disable iff (!rst_n)
    out_valid && exp_q |-> (out_tag == TAG_Q) && (out_ch == last_ch)); // R3

  AST_RSSI_AFTER_SAMPLE: assert property (@(posedge clk_fast) disable iff (!rst_n)
    out_valid && (out_tag == TAG_RSSI) |->
      (last_tag == TAG_Q || last_tag == TAG_IQ8) && (last_ch == out_ch)); // R5

  AST_VALID_ON_TICK: assert property (@(posedge clk_fast) disable iff (!rst_n)
    out_valid |-> $past(port_tick)); // R7

  AST_SLAVE_QUIET: assert property (@(posedge clk_fast) disable iff (!rst_n)
    !pclk_oe |-> !pclk_out); // R9

  AST_OVF_SET: assert property (@(posedge clk_fast) disable iff (!rst_n)
    |ovf_evt_v |=> ((overflow & $past(ovf_evt_v)) == $past(ovf_evt_v))); // R11

  AST_OVF_STICKY: assert property (@(posedge clk_fast) disable iff (!rst_n)
    (overflow & $past(overflow)) == $past(overflow)); // R11

endmodule

bind iq_port_fmt iq_port_fmt_chk #(.NCH(NCH)) u_chk (
  .clk_fast  (clk_fast),
  .rst_n     (rst_n),
  .ch_en     (ch_en),
  .pclk_out  (pclk_out),
  .pclk_oe   (pclk_oe),
  .out_valid (out_valid),
  .out_tag   (out_tag),
  .out_ch    (out_ch),
  .overflow  (overflow),
  .port_tick (port_tick),
  .take_v    (take_v),
  .ovf_evt_v (ovf_evt_v)
);

// File: tb/test_iq_port_fmt.sv
module test_iq_port_fmt;

  localparam int NCH = 6;
  localparam int DW  = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NCH-1:0]    ch_en = '1;
  logic              fmt_par = 1'b0;
  logic              rssi_every = 1'b0;
  logic              pclk_master = 1'b1;
  logic [1:0]        pclk_div = 2'b00;
  logic              pclk_in = 1'b0;
  logic              pclk_out, pclk_oe;
  logic [NCH-1:0]    smp_vld = '0;
  logic [NCH*DW-1:0] smp_i = '0;
  logic [NCH*DW-1:0] smp_q = '0;
  logic [NCH-1:0]    rssi_upd = '0;
  logic [NCH*DW-1:0] rssi_val = '0;
  logic              out_valid;
  logic [1:0]        out_tag;
  logic [2:0]        out_ch;
  logic [DW-1:0]     out_data;
  logic [NCH-1:0]    overflow;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  logic pclk_run = 1'b0;

  logic [1:0]  w_tag  [256];
  logic [2:0]  w_ch   [256];
  logic [15:0] w_data [256];
  int          w_cyc  [256];
  int          w_tot = 0;

  iq_port_fmt i_iq_port_fmt (
    .clk_fast(clk), .rst_n(rst_n), .ch_en(ch_en), .fmt_par(fmt_par),
    .rssi_every(rssi_every), .pclk_master(pclk_master), .pclk_div(pclk_div),
    .pclk_in(pclk_in), .pclk_out(pclk_out), .pclk_oe(pclk_oe),
    .smp_vld(smp_vld), .smp_i(smp_i), .smp_q(smp_q), .rssi_upd(rssi_upd),
    .rssi_val(rssi_val), .out_valid(out_valid), .out_tag(out_tag),
    .out_ch(out_ch), .out_data(out_data), .overflow(overflow)
  );

  always #10 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (out_valid && w_tot < 256) begin
      w_tag[w_tot]  <= out_tag;
      w_ch[w_tot]   <= out_ch;
      w_data[w_tot] <= out_data;
      w_cyc[w_tot]  <= cyc;
      w_tot         <= w_tot + 1;
    end
  end

  initial begin
    forever begin
      repeat (5) @(negedge clk);
      if (pclk_run) pclk_in = ~pclk_in;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_word(input string req, input int idx, input logic [1:0] tag,
                          input logic [2:0] ch, input logic [15:0] data);
    chk(req, $sformatf("word %0d tag", idx), 32'(w_tag[idx]), 32'(tag));
    chk(req, $sformatf("word %0d ch", idx), 32'(w_ch[idx]), 32'(ch));
    chk(req, $sformatf("word %0d data", idx), 32'(w_data[idx]), 32'(data));
  endtask

  task automatic push_smp(input int ch, input logic [15:0] vi, input logic [15:0] vq);
    @(negedge clk);
    smp_vld[ch] = 1'b1;
    smp_i[ch*DW +: DW] = vi;
    smp_q[ch*DW +: DW] = vq;
    @(negedge clk);
    smp_vld = '0;
  endtask

  task automatic push_rssi(input int ch, input logic [15:0] v);
    @(negedge clk);
    rssi_upd[ch] = 1'b1;
    rssi_val[ch*DW +: DW] = v;
    @(negedge clk);
    rssi_upd = '0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    wait_cyc(3);
    chk("R10", "pclk_oe in reset", 32'(pclk_oe), 0);
    chk("R10", "out_valid in reset", 32'(out_valid), 0);
    chk("R10", "overflow in reset", 32'(overflow), 0);
    rst_n = 1'b1;
    wait_cyc(3);
    chk("R8", "pclk_oe master", 32'(pclk_oe), 1);
  endtask

  task automatic t_interleaved_every;
    int b;
    rssi_every = 1'b1; fmt_par = 1'b0;
    push_rssi(2, 16'h0AB1);
    b = w_tot;
    push_smp(2, 16'h1234, 16'h5678);
    wait_cyc(20);
    chk("R5", "word count", 32'(w_tot - b), 3);
    chk_word("R3", b, 2'b00, 3'd2, 16'h1234);
    chk_word("R3", b + 1, 2'b01, 3'd2, 16'h5678);
    chk_word("R5", b + 2, 2'b10, 3'd2, 16'h0AB1);
  endtask

  task automatic t_parallel;
    int b;
    fmt_par = 1'b1; rssi_every = 1'b1;
    push_rssi(5, 16'h7777);
    b = w_tot;
    push_smp(5, 16'hA1B2, 16'hC3D4);
    wait_cyc(20);
    chk("R4", "word count", 32'(w_tot - b), 2);
    chk_word("R4", b, 2'b11, 3'd5, 16'hA1C3);
    chk_word("R5", b + 1, 2'b10, 3'd5, 16'h7777);
    fmt_par = 1'b0;
  endtask

  task automatic t_fresh_only;
    int b;
    rssi_every = 1'b0;
    push_rssi(0, 16'h1111);
    b = w_tot;
    push_smp(0, 16'h0001, 16'h0002);
    wait_cyc(15);
    push_smp(0, 16'h0003, 16'h0004);
    wait_cyc(15);
    chk("R6", "words for two samples", 32'(w_tot - b), 5);
    chk_word("R6", b + 2, 2'b10, 3'd0, 16'h1111);
    chk_word("R6", b + 3, 2'b00, 3'd0, 16'h0003);
    chk_word("R6", b + 4, 2'b01, 3'd0, 16'h0004);
    push_rssi(0, 16'h2222);
    b = w_tot;
    push_smp(0, 16'h0005, 16'h0006);
    wait_cyc(15);
    chk("R6", "words after new update", 32'(w_tot - b), 3);
    chk_word("R6", b + 2, 2'b10, 3'd0, 16'h2222);
  endtask

  task automatic t_order;
    int b;
    b = w_tot;
    @(negedge clk);
    smp_vld = 6'b011010;
    smp_i[1*DW +: DW] = 16'h0101; smp_q[1*DW +: DW] = 16'h0111;
    smp_i[3*DW +: DW] = 16'h0303; smp_q[3*DW +: DW] = 16'h0333;
    smp_i[4*DW +: DW] = 16'h0404; smp_q[4*DW +: DW] = 16'h0444;
    @(negedge clk);
    smp_vld = '0;
    wait_cyc(20);
    chk("R2", "word count", 32'(w_tot - b), 6);
    chk_word("R2", b, 2'b00, 3'd1, 16'h0101);
    chk_word("R2", b + 1, 2'b01, 3'd1, 16'h0111);
    chk_word("R2", b + 2, 2'b00, 3'd3, 16'h0303);
    chk_word("R2", b + 4, 2'b00, 3'd4, 16'h0404);
    chk_word("R2", b + 5, 2'b01, 3'd4, 16'h0444);
  endtask

  task automatic t_disabled;
    int b;
    ch_en = 6'b111011;
    b = w_tot;
    push_smp(2, 16'hDEAD, 16'hBEEF);
    push_smp(2, 16'hFACE, 16'hCAFE);
    wait_cyc(20);
    chk("R1", "words from disabled ch", 32'(w_tot - b), 0);
    chk("R1", "overflow disabled ch", 32'(overflow[2]), 0);
    ch_en = '1;
    wait_cyc(10);
    chk("R1", "no stale word after enable", 32'(w_tot - b), 0);
  endtask

  task automatic t_overflow;
    int b;
    @(negedge clk);
    pclk_master = 1'b0; pclk_run = 1'b0; pclk_in = 1'b0;
    wait_cyc(6);
    b = w_tot;
    push_smp(0, 16'h0010, 16'h0020);
    push_smp(0, 16'h0030, 16'h0040);
    wait_cyc(2);
    chk("R11", "overflow after overwrite", 32'(overflow), 32'h01);
    chk("R9", "no word without pclk_in", 32'(w_tot - b), 0);
    pclk_run = 1'b1;
    wait_cyc(40);
    pclk_run = 1'b0;
    chk("R11", "word count", 32'(w_tot - b), 2);
    chk_word("R11", b, 2'b00, 3'd0, 16'h0030);
    chk_word("R11", b + 1, 2'b01, 3'd0, 16'h0040);
    chk("R11", "overflow sticky", 32'(overflow), 32'h01);
  endtask

  task automatic t_slave_pace;
    int b;
    pclk_div = 2'b11;
    pclk_run = 1'b1;
    wait_cyc(12);
    b = w_tot;
    push_smp(1, 16'h00A0, 16'h00B0);
    wait_cyc(40);
    pclk_run = 1'b0;
    chk("R9", "word count", 32'(w_tot - b), 2);
    chk("R9", "I to Q spacing", 32'(w_cyc[b + 1] - w_cyc[b]), 10);
    chk("R9", "pclk_oe slave", 32'(pclk_oe), 0);
    chk("R9", "pclk_out slave", 32'(pclk_out), 0);
  endtask

  task automatic t_master_div;
    int b;
    int ones;
    @(negedge clk);
    pclk_master = 1'b1; pclk_div = 2'b10; rssi_every = 1'b1;
    wait_cyc(8);
    chk("R8", "pclk_oe master", 32'(pclk_oe), 1);
    ones = 0;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      if (pclk_out) ones++;
    end
    chk("R8", "pclk_out high count over 16", 32'(ones), 8);
    b = w_tot;
    push_smp(3, 16'h3300, 16'h3311);
    wait_cyc(30);
    chk("R8", "word count div4", 32'(w_tot - b), 3);
    chk("R8", "spacing I-Q div4", 32'(w_cyc[b + 1] - w_cyc[b]), 4);
    chk("R8", "spacing Q-RSSI div4", 32'(w_cyc[b + 2] - w_cyc[b + 1]), 4);
    chk_word("R5", b + 2, 2'b10, 3'd3, 16'h0000);
    rssi_every = 1'b0;
    pclk_div = 2'b11;
    wait_cyc(10);
    b = w_tot;
    push_smp(4, 16'h4400, 16'h4411);
    wait_cyc(40);
    chk("R8", "word count div8", 32'(w_tot - b), 2);
    chk("R8", "spacing I-Q div8", 32'(w_cyc[b + 1] - w_cyc[b]), 8);
    chk("R7", "pulse length", 32'(out_valid), 0);
  endtask

  initial begin
    t_reset;
    t_interleaved_every;
    t_parallel;
    t_fresh_only;
    t_order;
    t_disabled;
    t_overflow;
    t_slave_pace;
    t_master_div;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(20 * 100000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule